// File: doc/BRIEF.md
# GPIO Port with Atomic Set/Clear Registers

This block is a register-mapped general-purpose pin port of up to 32 lines. It holds two state registers: one for the output levels and one for the pin directions. Neither has a direct-write address. Each is changed only by writing a mask to a dedicated "set" address or a dedicated "clear" address. Several agents can therefore flip their own pins without a read-modify-write sequence and without disturbing one another.

The direction register can be read back at a status address. The pin input levels pass through a two-stage synchroniser and a sample register, and they can be read at a separate address. The register bus is a plain synchronous 32-bit interface with an address, a write enable, write data and read data. Read data is combinational from the address.

Each pin has three signals. Its output value comes from its data bit, its output enable comes from its direction bit, and it has an input value. The parameter `NUM_LINES` (1 to 32) sets how many lines are built. The parameter `ADDR_W` (at least 8) sets the bus address width. Every address is compared in full, so a misaligned or aliased address is treated as unowned.

Top module: `gpio_setclr_port`

## Requirements
- R1: After reset, `pin_out` and `pin_oe` are all 0, and the direction status read returns 0.
- R2: A write to address 0x000 sets to 1 every data bit whose write-data bit is 1. All other data bits keep their value. The change is visible on `pin_out` after the clock edge that takes the write.
- R3: A write to address 0x004 clears to 0 every data bit whose write-data bit is 1. All other data bits keep their value.
- R4: A write to address 0x010 sets the selected direction bits, which makes those pins outputs (`pin_oe` = 1). A write to address 0x014 clears the selected direction bits, which makes those pins inputs. Unselected direction bits keep their value.
- R5: A read at address 0x018 returns the direction register in bits [NUM_LINES-1:0].
- R6: A read at address 0x080 returns the pin input levels. The path is two synchroniser flops followed by a sample flop, so a change on `pin_in` is first visible on the bus after the third rising clock edge, and not after the second.
- R7: Write-data bits at or above `NUM_LINES` are ignored. Read-data bits at or above `NUM_LINES` are always 0.
- R8: A write to any other address has no effect, including the read-only addresses 0x018 and 0x080. A cycle with the write enable low changes nothing. A read of any address other than 0x018 and 0x080 returns 0, and this includes the write-only set/clear addresses.
- R9: `pin_out` follows the data register whatever the direction, and `pin_oe` follows the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write enable for the current cycle |
| bus_wdata | input | 32 | Write data (set or clear mask) |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_out | output | NUM_LINES | Per-pin output value |
| pin_oe | output | NUM_LINES | Per-pin output enable (1 = output) |
| pin_in | input | NUM_LINES | Per-pin input level, asynchronous |

## Verification
The bench builds the port with `NUM_LINES` = 20 and `ADDR_W` = 8. With 20 lines, the twelve upper bus bits exist on the bus but have no line behind them. All-ones masks and all-ones pin levels can then show that these bits are dropped on write and read back as 0. The 8-bit address lets the bench reach every unowned offset, and it mixes writes to those offsets with random set/clear traffic against a bench model.

// File: rtl/gpio_setclr_pkg.sv
// Shared constants for the set/clear GPIO port.
// Assumes byte addresses with full-width comparison; offsets fit in 8 bits.
package gpio_setclr_pkg;
    localparam int unsigned BUS_W       = 32;
    localparam int unsigned OFF_DAT_SET = 32'h000;
    localparam int unsigned OFF_DAT_CLR = 32'h004;
    localparam int unsigned OFF_DIR_SET = 32'h010;
    localparam int unsigned OFF_DIR_CLR = 32'h014;
    localparam int unsigned OFF_DIR_ST  = 32'h018;
    localparam int unsigned OFF_PINS    = 32'h080;

    // Decoded access for one bus cycle.
    typedef struct packed {
        logic dat_set;
        logic dat_clr;
        logic dir_set;
        logic dir_clr;
        logic rd_dir;
        logic rd_pins;
    } gpio_acc_t;
endpackage

// File: rtl/gpio_reg_decode.sv
// Address decoder: turns the bus address and write enable into one-hot
// write strobes and read selects. Assumes ADDR_W >= 8 and that the whole
// address is compared, so aliases and misaligned addresses decode to nothing.
module gpio_reg_decode
    import gpio_setclr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output gpio_acc_t         acc
);
    // Compare the address against each owned offset.
    always_comb begin
        acc         = '0;
        acc.dat_set = wr && (addr == ADDR_W'(OFF_DAT_SET));
        acc.dat_clr = wr && (addr == ADDR_W'(OFF_DAT_CLR));
        acc.dir_set = wr && (addr == ADDR_W'(OFF_DIR_SET));
        acc.dir_clr = wr && (addr == ADDR_W'(OFF_DIR_CLR));
        acc.rd_dir  = (addr == ADDR_W'(OFF_DIR_ST));
        acc.rd_pins = (addr == ADDR_W'(OFF_PINS));
    end
endmodule

// File: rtl/gpio_setclr_reg.sv
// Register changed only by per-bit set and clear strobes.
// Assumes set and clear never strobe in the same cycle (one address per
// cycle); if they did, clear wins. Resets to all zeros.
module gpio_setclr_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_stb,
    input  logic             clr_stb,
    input  logic [WIDTH-1:0] mask,
    output logic [WIDTH-1:0] q
);
    // Apply the mask as set or clear; unmasked bits hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (clr_stb) q <= q & ~mask;
        else if (set_stb) q <= q | mask;
    end
endmodule

// File: rtl/gpio_in_sync.sv
// Input path: SYNC_STAGES synchroniser flops per pin, then one sample flop
// that forms the pin-level register. Assumes pins are asynchronous levels.
module gpio_in_sync #(
    parameter int WIDTH       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins,
    output logic [WIDTH-1:0] level
);
    logic [WIDTH-1:0] stage [SYNC_STAGES];

    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First flop: capture the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[0] <= '0;
                else        stage[0] <= pins;
            end
        end else begin : g_next
            // Later flops: let metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[s] <= '0;
                else        stage[s] <= stage[s-1];
            end
        end
    end

    // Sample register read by the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) level <= '0;
        else        level <= stage[SYNC_STAGES-1];
    end
endmodule

// File: rtl/gpio_setclr_port.sv
// Top of the set/clear GPIO port. Decodes the register bus, holds the data
// and direction registers, and synchronises the inputs. Assumes
// 1 <= NUM_LINES <= 32 and ADDR_W >= 8. Read data is combinational.
module gpio_setclr_port
    import gpio_setclr_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    output logic [NUM_LINES-1:0] pin_out,
    output logic [NUM_LINES-1:0] pin_oe,
    input  logic [NUM_LINES-1:0] pin_in
);
    localparam int SYNC_STAGES = 2;

    gpio_acc_t            acc;
    logic [NUM_LINES-1:0] wmask;
    logic [NUM_LINES-1:0] dat_q;
    logic [NUM_LINES-1:0] dir_q;
    logic [NUM_LINES-1:0] pin_lvl;

    assign wmask = bus_wdata[NUM_LINES-1:0];

    if (NUM_LINES < BUS_W) begin : g_hi
        logic unused_wdata_hi;
        assign unused_wdata_hi = ^bus_wdata[BUS_W-1:NUM_LINES];
    end

    gpio_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .acc  (acc)
    );

    gpio_setclr_reg #(.WIDTH(NUM_LINES)) u_dat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (acc.dat_set),
        .clr_stb (acc.dat_clr),
        .mask    (wmask),
        .q       (dat_q)
    );

    gpio_setclr_reg #(.WIDTH(NUM_LINES)) u_dir (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (acc.dir_set),
        .clr_stb (acc.dir_clr),
        .mask    (wmask),
        .q       (dir_q)
    );

    gpio_in_sync #(.WIDTH(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  (pin_in),
        .level (pin_lvl)
    );

    // Pin drive straight from the state registers.
    assign pin_out = dat_q;
    assign pin_oe  = dir_q;

    // Read mux; unowned and write-only addresses return zero.
    always_comb begin
        bus_rdata = '0;
        if (acc.rd_dir)       bus_rdata = BUS_W'(dir_q);
        else if (acc.rd_pins) bus_rdata = BUS_W'(pin_lvl);
    end
endmodule

// File: rtl/gpio_setclr_port_chk.sv
// Checker for gpio_setclr_port: relates bus writes to pin outputs and
// read data. Uses only the top-level ports.
module gpio_setclr_port_chk
    import gpio_setclr_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_wr,
    input logic [BUS_W-1:0]     bus_wdata,
    input logic [BUS_W-1:0]     bus_rdata,
    input logic [NUM_LINES-1:0] pin_out,
    input logic [NUM_LINES-1:0] pin_oe
);
    localparam logic [BUS_W-1:0] LINE_MASK = BUS_W'((64'd1 << NUM_LINES) - 64'd1);

    logic [BUS_W-1:0] wm;
    logic [BUS_W-1:0] po;
    logic [BUS_W-1:0] oe;
    logic             w_dset, w_dclr, w_oset, w_oclr, w_own;
    assign wm     = bus_wdata & LINE_MASK;
    assign po     = BUS_W'(pin_out);
    assign oe     = BUS_W'(pin_oe);
    assign w_dset = bus_wr && bus_addr == ADDR_W'(OFF_DAT_SET);
    assign w_dclr = bus_wr && bus_addr == ADDR_W'(OFF_DAT_CLR);
    assign w_oset = bus_wr && bus_addr == ADDR_W'(OFF_DIR_SET);
    assign w_oclr = bus_wr && bus_addr == ADDR_W'(OFF_DIR_CLR);
    assign w_own  = w_dset || w_dclr || w_oset || w_oclr;

    a_r2_data_set: assert property (@(posedge clk) disable iff (!rst_n)
        w_dset |=> ((po & $past(wm)) == $past(wm)) &&
                   (((po ^ $past(po)) & ~$past(wm)) == '0));

    a_r3_data_clr: assert property (@(posedge clk) disable iff (!rst_n)
        w_dclr |=> ((po & $past(wm)) == '0) &&
                   (((po ^ $past(po)) & ~$past(wm)) == '0));

    a_r4_dir_set: assert property (@(posedge clk) disable iff (!rst_n)
        w_oset |=> ((oe & $past(wm)) == $past(wm)) && $stable(pin_out));

    a_r4_dir_clr: assert property (@(posedge clk) disable iff (!rst_n)
        w_oclr |=> ((oe & $past(wm)) == '0) && $stable(pin_out));

    a_r5_dir_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_DIR_ST)) |-> (bus_rdata == oe));

    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~LINE_MASK) == '0);

    a_r8_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !w_own |=> $stable(pin_out) && $stable(pin_oe));

    a_r8_unowned_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != ADDR_W'(OFF_DIR_ST) && bus_addr != ADDR_W'(OFF_PINS))
        |-> (bus_rdata == '0));
endmodule

bind gpio_setclr_port gpio_setclr_port_chk #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_setclr_port_bench.sv
// Bench for gpio_setclr_port: directed corners plus seeded random
// set/clear traffic, checked against a bench-side model.
module gpio_setclr_port_bench;
    localparam int NL = 20;
    localparam int AW = 8;
    localparam logic [31:0] LM = 32'h000F_FFFF;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] pin_out, pin_oe;
    logic [NL-1:0] pin_in = '0;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] m_dat = '0;
    logic [31:0] m_dir = '0;
    int unsigned seed = 32'h1234_5678;

    always #5 clk = ~clk;

    gpio_setclr_port #(.NUM_LINES(NL), .ADDR_W(AW)) u_gpio_setclr_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in)
    );

    function automatic logic [31:0] f_set(logic [31:0] old, logic [31:0] m);
        return (old | m) & LM;
    endfunction
    function automatic logic [31:0] f_clr(logic [31:0] old, logic [31:0] m);
        return old & ~m & LM;
    endfunction
    function automatic bit f_owned(logic [7:0] a);
        return a == 8'h00 || a == 8'h04 || a == 8'h10 || a == 8'h14;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0; bus_addr = 8'hFE;
        case (a)
            8'h00: m_dat = f_set(m_dat, d);
            8'h04: m_dat = f_clr(m_dat, d);
            8'h10: m_dir = f_set(m_dir, d);
            8'h14: m_dir = f_clr(m_dir, d);
            default: ;
        endcase
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 0;
        #1 d = bus_rdata;
    endtask

    task automatic check_pins(string tag);
        #1;
        check({tag, " pin_out"}, 32'(pin_out), m_dat);
        check({tag, " pin_oe"}, 32'(pin_oe), m_dir);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        check_pins("R1 reset");
        rd(8'h18, r); check("R1 dir read", r, 32'h0);

        // R2 set, R9 output value while pin is an input
        wr(8'h00, 32'h0000_00A5); check_pins("R2 set");
        check("R9 out while input", 32'(pin_out & ~pin_oe), 32'h0000_00A5);
        wr(8'h00, 32'h0000_0F00); check_pins("R2 set keeps others");
        // R3 clear
        wr(8'h04, 32'h0000_0081); check_pins("R3 clear");
        // R4 direction set/clear, R5 status read
        wr(8'h10, 32'h000F_0F0F); check_pins("R4 dir set");
        rd(8'h18, r); check("R5 dir read", r, m_dir);
        wr(8'h14, 32'h0000_0F00); check_pins("R4 dir clear");
        check("R9 oe follows dir", 32'(pin_oe), 32'h000F_000F);
        rd(8'h18, r); check("R5 dir read after clear", r, 32'h000F_000F);

        // R7 upper bits ignored and read as zero
        wr(8'h00, 32'hFFFF_FFFF); check_pins("R7 set all");
        check("R7 pin_out all lines", 32'(pin_out), LM);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h18, r); check("R7 dir read upper zero", r, LM);

        // R8 unowned and read-only writes have no effect
        wr(8'h04, 32'h0000_3333);
        wr(8'h01, 32'hFFFF_FFFF); wr(8'h08, 32'h0);
        wr(8'h18, 32'h0); wr(8'h80, 32'h0); wr(8'h84, 32'hFFFF_FFFF);
        wr(8'h15, 32'hFFFF_FFFF);
        check_pins("R8 unowned writes");
        @(negedge clk); bus_addr = 8'h04; bus_wdata = 32'hFFFF_FFFF; bus_wr = 0;
        @(negedge clk); check_pins("R8 write enable low");
        foreach (r[i]) ;
        rd(8'h00, r); check("R8 read set addr", r, 0);
        rd(8'h04, r); check("R8 read clr addr", r, 0);
        rd(8'h10, r); check("R8 read dirset addr", r, 0);
        rd(8'h14, r); check("R8 read dirclr addr", r, 0);
        rd(8'h19, r); check("R8 read unowned", r, 0);
        rd(8'hFC, r); check("R8 read high unowned", r, 0);

        // R6 input latency: old after two edges, new after third
        @(negedge clk); pin_in = 20'hA_5A5A;
        repeat (2) @(posedge clk);
        rd(8'h80, r); check("R6 before third edge", r, 0);
        @(posedge clk);
        rd(8'h80, r); check("R6 after third edge", r, 32'h000A_5A5A);
        @(negedge clk); pin_in = '1;
        repeat (4) @(posedge clk);
        rd(8'h80, r); check("R7 pin read upper zero", r, LM);

        // Random traffic (R2 R3 R4 R5 R6 R8)
        void'($urandom(seed));
        for (int i = 0; i < 400; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            int          op;
            op = $urandom_range(0, 5);
            d  = $urandom;
            case (op)
                0: a = 8'h00;
                1: a = 8'h04;
                2: a = 8'h10;
                3: a = 8'h14;
                default: begin
                    a = 8'($urandom);
                    while (f_owned(a)) a = 8'($urandom);
                end
            endcase
            wr(a, d);
            check_pins("R2 R3 R4 R8 random");
            if (i % 8 == 0) begin
                rd(8'h18, r); check("R5 random dir read", r, m_dir);
                @(negedge clk); pin_in = NL'($urandom);
                repeat (3) @(posedge clk);
                rd(8'h80, r); check("R6 random pins", r, 32'(pin_in));
            end
        end

        summary();
    end
endmodule